// File: doc/BRIEF.md
# Static Memory Write Cycle Generator

This block drives one write access on an external asynchronous static-memory bus. A single-clock start request carries a word address, a 32-bit data word and four byte enables. The block latches them, together with the timing settings and the control-mode bit, and then produces an active-low chip select, an active-low write strobe and active-low byte selects. The shape of each strobe is set by its own setup and pulse counts. The total length of the access is set by a separate cycle count. All counts are in clocks of the block's clock.

The data bus driver is controlled by a mode bit. In strobe-controlled mode, the driver turns on once the write-strobe setup count has elapsed. In select-controlled mode, it turns on once the chip-select setup count has elapsed. In both modes the driver then stays on until the last clock of the access, so data is valid throughout the pulse and hold phases of the controlling signal. The timing of the other signal has no effect on the driver.

A one-clock done pulse marks the last clock of the access. On the clock after it, every output is back at idle.

Top module: `smem_wr_cycle`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), and whenever no access is running, cs_n_o, we_n_o and all bits of bsel_n_o are 1, dq_oe_o, done_o are 0 and dq_o is 0; a reset in the middle of an access returns all of these to idle at the next edge.
- R2: start_i high at a clock edge while idle begins an access; counting the clock after that edge as access clock k=0, the access occupies k=0..L-1, where L is cyc_len_i, and a cyc_len_i of 0 is treated as 1.
- R3: Each strobe (we_n_o with we_setup_i/we_pulse_i, cs_n_o with cs_setup_i/cs_pulse_i) is 0 exactly for access clocks k with setup <= k < setup+pulse and k < L, and 1 otherwise; a pulse count of 0 leaves the strobe high.
- R4: With ctrl_sel_i = 1 (strobe-controlled), dq_oe_o is 1 exactly for access clocks k with we_setup_i <= k < L, whatever the chip-select timing is.
- R5: With ctrl_sel_i = 0 (select-controlled), dq_oe_o is 1 exactly for access clocks k with cs_setup_i <= k < L, whatever the write-strobe timing is.
- R6: A setup count of 0 makes that strobe (if its pulse is nonzero) and, for the controlling strobe, dq_oe_o active at access clock k=0.
- R7: During an access, waddr_o equals the latched waddr_i, bsel_n_o equals the bitwise inverse of the latched be_i (bit n for data bits 8n+7..8n), and dq_o equals the latched wdata_i while dq_oe_o is 1.
- R8: start_i high during an access, including on its last clock, is ignored: the running access keeps its length and waveforms.
- R9: done_o is 1 only on access clock k=L-1; on the next clock all outputs are idle as in R1.
- R10: Address, data, byte enables, mode and all timing counts are sampled at the start edge; changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin an access (sampled while idle) |
| waddr_i | input | 24 | Word address of the access |
| wdata_i | input | 32 | Data word to write |
| be_i | input | 4 | Active-high byte enables, bit n for byte n |
| ctrl_sel_i | input | 1 | 1: write strobe controls data drive, 0: chip select controls it |
| we_setup_i | input | 6 | Write-strobe setup count |
| we_pulse_i | input | 6 | Write-strobe low count |
| cs_setup_i | input | 6 | Chip-select setup count |
| cs_pulse_i | input | 6 | Chip-select low count |
| cyc_len_i | input | 6 | Total access length in clocks |
| cs_n_o | output | 1 | Active-low chip select |
| we_n_o | output | 1 | Active-low write strobe |
| bsel_n_o | output | 4 | Active-low byte selects |
| waddr_o | output | 24 | Word address on the bus |
| dq_o | output | 32 | Data bus value |
| dq_oe_o | output | 1 | Data bus output enable |
| done_o | output | 1 | One-clock pulse on the last access clock |

## Verification
On every clock, the assertions check the following. The controlling strobe is never low without the data driver on. Once on, the driver stays on until the done clock. Done is always followed by an idle bus. Latched address and data do not move while an access runs. The access counter advances by one regardless of start requests. The exact clock at which each strobe falls and rises, how a zero or oversized count behaves, and the fact that the driver's timing is the same when only the non-controlling strobe's settings change can only be shown by the bench. It does this by comparing whole access waveforms against values computed from the requirements.

// File: rtl/smem_wr_pkg.sv
// Package: shared definitions for the static-memory write cycle generator.
// Assumes two strobes, indexed by the constants below.
package smem_wr_pkg;

    // Which strobe governs the data driver.
    typedef enum logic {
        CTRL_BY_CS = 1'b0,
        CTRL_BY_WE = 1'b1
    } wr_ctrl_e;

    localparam int unsigned NUM_STROBES = 2;
    localparam int unsigned SIDX_WE     = 0;
    localparam int unsigned SIDX_CS     = 1;

endpackage

// File: rtl/smem_wr_seq.sv
// Module: access sequencer. Accepts a start while idle, latches the access
// length (0 treated as 1), and counts access clocks 0..L-1, flagging the last.
// Assumes start_i is synchronous to clk.
module smem_wr_seq #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;

    // Accept a new access only when no access is running.
    assign accept_o = start_i && !busy_q;
    assign done_o   = busy_q && (cnt_q == last_q);
    assign busy_o   = busy_q;
    assign cnt_o    = cnt_q;

    // Advance the access counter and end the access on its last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            last_q <= '0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            last_q <= (len_i == '0) ? '0 : len_i - CNT_W'(1);
        end else if (busy_q) begin
            if (done_o) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R9: the clock after done is idle.
    p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_q);

    // R8: a running access keeps counting whatever start_i does.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done_o) |=> (busy_q && cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R2: an accepted start opens the access at clock zero.
    p_accept_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (busy_q && cnt_q == '0));

endmodule

// File: rtl/smem_wr_strobe.sv
// Module: one strobe shaper. Latches its setup and pulse counts at the start
// edge and drives an active-low strobe that is low for access clocks in
// [setup, setup+pulse). Also reports whether the setup phase has elapsed.
// Assumes cnt_i counts access clocks from zero while busy_i is high.
module smem_wr_strobe #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] setup_i,
    input  logic [CNT_W-1:0] pulse_i,
    input  logic             busy_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             strobe_n_o,
    output logic             setup_done_o
);

    logic [CNT_W-1:0] setup_q;
    logic [CNT_W:0]   end_q;

    // Capture this strobe's timing when an access begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
            end_q   <= '0;
        end else if (load_i) begin
            setup_q <= setup_i;
            end_q   <= {1'b0, setup_i} + {1'b0, pulse_i};
        end
    end

    // Decode the strobe level and setup-elapsed flag from the access count.
    always_comb begin
        setup_done_o = busy_i && (cnt_i >= setup_q);
        strobe_n_o   = !(setup_done_o && ({1'b0, cnt_i} < end_q));
    end

    // R3: a nonzero setup keeps the strobe high on the first access clock.
    p_setup_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && setup_i != '0) |=> strobe_n_o);

    // R6: a zero setup with a nonzero pulse drives the strobe low at once.
    p_setup_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && setup_i == '0 && pulse_i != '0) |=> !strobe_n_o);

endmodule

// File: rtl/smem_wr_dpath.sv
// Module: write data path. Latches word address, data, byte enables and the
// control-mode bit at the start edge; drives the bus and its enable from the
// setup-elapsed flag of whichever strobe the mode selects.
// Assumes busy_i is high for exactly the access clocks.
module smem_wr_dpath
    import smem_wr_pkg::*;
#(
    parameter int unsigned WADDR_W = 24,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned BE_W    = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [WADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [BE_W-1:0]    be_i,
    input  logic               ctrl_sel_i,
    input  logic               busy_i,
    input  logic               we_setup_done_i,
    input  logic               cs_setup_done_i,
    output wr_ctrl_e           mode_o,
    output logic [WADDR_W-1:0] waddr_o,
    output logic [BE_W-1:0]    bsel_n_o,
    output logic [DATA_W-1:0]  dq_o,
    output logic               dq_oe_o
);

    logic [WADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [BE_W-1:0]    be_q;
    wr_ctrl_e           mode_q;

    // Capture the access payload and control mode when an access begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
            mode_q <= CTRL_BY_CS;
        end else if (load_i) begin
            addr_q <= waddr_i;
            data_q <= wdata_i;
            be_q   <= be_i;
            mode_q <= wr_ctrl_e'(ctrl_sel_i);
        end
    end

    // Select the governing strobe and drive the bus outputs.
    always_comb begin
        dq_oe_o  = busy_i && ((mode_q == CTRL_BY_WE) ? we_setup_done_i
                                                      : cs_setup_done_i);
        dq_o     = dq_oe_o ? data_q : '0;
        bsel_n_o = busy_i ? ~be_q : '1;
        waddr_o  = addr_q;
        mode_o   = mode_q;
    end

    // R7 / R10: the latched payload does not move while an access runs.
    p_payload_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(addr_q) && $stable(data_q) && $stable(be_q)
                    && $stable(mode_q)));

endmodule

// File: rtl/smem_wr_cycle.sv
// Module: static-memory write cycle generator (top). Ties the sequencer, the
// two strobe shapers and the data path together.
// Assumes timing inputs are valid in the clock where start_i is accepted.
module smem_wr_cycle
    import smem_wr_pkg::*;
#(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start_i,
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] waddr_i,
    input  logic [DATA_W-1:0]                  wdata_i,
    input  logic [DATA_W/8-1:0]                be_i,
    input  logic                               ctrl_sel_i,
    input  logic [CNT_W-1:0]                   we_setup_i,
    input  logic [CNT_W-1:0]                   we_pulse_i,
    input  logic [CNT_W-1:0]                   cs_setup_i,
    input  logic [CNT_W-1:0]                   cs_pulse_i,
    input  logic [CNT_W-1:0]                   cyc_len_i,
    output logic                               cs_n_o,
    output logic                               we_n_o,
    output logic [DATA_W/8-1:0]                bsel_n_o,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] waddr_o,
    output logic [DATA_W-1:0]                  dq_o,
    output logic                               dq_oe_o,
    output logic                               done_o
);

    localparam int unsigned BE_W    = DATA_W / 8;
    localparam int unsigned WADDR_W = ADDR_W - $clog2(BE_W);

    logic             accept;
    logic             busy;
    logic [CNT_W-1:0] cnt;
    wr_ctrl_e         mode;

    logic [CNT_W-1:0]       setup_arr [NUM_STROBES];
    logic [CNT_W-1:0]       pulse_arr [NUM_STROBES];
    logic [NUM_STROBES-1:0] strobe_n;
    logic [NUM_STROBES-1:0] setup_done;

    // Route each strobe's timing inputs to its shaper slot.
    always_comb begin
        setup_arr[SIDX_WE] = we_setup_i;
        pulse_arr[SIDX_WE] = we_pulse_i;
        setup_arr[SIDX_CS] = cs_setup_i;
        pulse_arr[SIDX_CS] = cs_pulse_i;
    end

    smem_wr_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .len_i    (cyc_len_i),
        .accept_o (accept),
        .busy_o   (busy),
        .cnt_o    (cnt),
        .done_o   (done_o)
    );

    for (genvar s = 0; s < NUM_STROBES; s++) begin : g_strobe
        smem_wr_strobe #(.CNT_W(CNT_W)) u_strobe (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_i       (accept),
            .setup_i      (setup_arr[s]),
            .pulse_i      (pulse_arr[s]),
            .busy_i       (busy),
            .cnt_i        (cnt),
            .strobe_n_o   (strobe_n[s]),
            .setup_done_o (setup_done[s])
        );
    end

    smem_wr_dpath #(
        .WADDR_W (WADDR_W),
        .DATA_W  (DATA_W),
        .BE_W    (BE_W)
    ) u_dpath (
        .clk             (clk),
        .rst_n           (rst_n),
        .load_i          (accept),
        .waddr_i         (waddr_i),
        .wdata_i         (wdata_i),
        .be_i            (be_i),
        .ctrl_sel_i      (ctrl_sel_i),
        .busy_i          (busy),
        .we_setup_done_i (setup_done[SIDX_WE]),
        .cs_setup_done_i (setup_done[SIDX_CS]),
        .mode_o          (mode),
        .waddr_o         (waddr_o),
        .bsel_n_o        (bsel_n_o),
        .dq_o            (dq_o),
        .dq_oe_o         (dq_oe_o)
    );

    assign we_n_o = strobe_n[SIDX_WE];
    assign cs_n_o = strobe_n[SIDX_CS];

    // R4: in strobe-controlled mode the strobe is never low with the bus off.
    p_we_data_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CTRL_BY_WE && !we_n_o) |-> dq_oe_o);

    // R5: in select-controlled mode the select is never low with the bus off.
    p_cs_data_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CTRL_BY_CS && !cs_n_o) |-> dq_oe_o);

    // R4 / R5: once on, the driver stays on until the done clock.
    p_oe_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o && !done_o) |=> dq_oe_o);

    // R9: the bus is idle on the clock after done.
    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (cs_n_o && we_n_o && !dq_oe_o && (&bsel_n_o) && !done_o));

endmodule

// File: tb/smem_wr_cycle_tb.sv
`timescale 1ns/1ps
module smem_wr_cycle_tb;

    localparam int CNT_W = 6;

    typedef struct packed {
        logic             mode;
        logic [CNT_W-1:0] ws;
        logic [CNT_W-1:0] wp;
        logic [CNT_W-1:0] cs;
        logic [CNT_W-1:0] cp;
        logic [CNT_W-1:0] len;
    } vec_t;

    // mode, we setup, we pulse, cs setup, cs pulse, length
    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 6'd2, 6'd3, 6'd1, 6'd5, 6'd7},  // R4 strobe-controlled
        '{1'b1, 6'd2, 6'd3, 6'd0, 6'd2, 6'd7},  // R4 same, other cs timing
        '{1'b0, 6'd1, 6'd4, 6'd3, 6'd2, 6'd8},  // R5 select-controlled
        '{1'b0, 6'd5, 6'd1, 6'd3, 6'd2, 6'd8},  // R5 same, other we timing
        '{1'b1, 6'd0, 6'd2, 6'd0, 6'd3, 6'd4},  // R6 zero setups
        '{1'b0, 6'd0, 6'd1, 6'd2, 6'd9, 6'd5},  // R6 / R3 pulse truncated
        '{1'b1, 6'd1, 6'd1, 6'd1, 6'd1, 6'd1},  // R2 one-clock access
        '{1'b0, 6'd3, 6'd2, 6'd0, 6'd0, 6'd0}   // R2 zero length, R3 zero pulse
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] waddr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [3:0]  be_i = '0;
    logic        ctrl_sel_i = 1'b0;
    logic [5:0]  we_setup_i = '0, we_pulse_i = '0, cs_setup_i = '0;
    logic [5:0]  cs_pulse_i = '0, cyc_len_i = '0;
    logic        cs_n_o, we_n_o, dq_oe_o, done_o;
    logic [3:0]  bsel_n_o;
    logic [23:0] waddr_o;
    logic [31:0] dq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [63:0] oe_mask [NVEC];

    always #5 clk = ~clk;

    smem_wr_cycle u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .waddr_i(waddr_i),
        .wdata_i(wdata_i), .be_i(be_i), .ctrl_sel_i(ctrl_sel_i),
        .we_setup_i(we_setup_i), .we_pulse_i(we_pulse_i),
        .cs_setup_i(cs_setup_i), .cs_pulse_i(cs_pulse_i),
        .cyc_len_i(cyc_len_i), .cs_n_o(cs_n_o), .we_n_o(we_n_o),
        .bsel_n_o(bsel_n_o), .waddr_o(waddr_o), .dq_o(dq_o),
        .dq_oe_o(dq_oe_o), .done_o(done_o)
    );

    function automatic bit low_at(int k, int s, int p, int l);
        return (k < l) && (k >= s) && (k < s + p);
    endfunction

    task automatic check(string req, logic [95:0] act, logic [95:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_idle(string req);
        check(req, {62'd0, cs_n_o, we_n_o, dq_oe_o, done_o, bsel_n_o, dq_o},
                   {62'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 32'd0});
    endtask

    // Run one access and compare every clock against computed waveforms.
    // disturb: at k=2 hold start high and change every input (R8, R10).
    task automatic run_access(vec_t v, logic [23:0] a, logic [31:0] d,
                              logic [3:0] b, string req, bit disturb,
                              output logic [63:0] oemask);
        int l;
        int ctl_setup;
        bit e_we, e_cs, e_oe, e_done;
        l = (v.len == 0) ? 1 : int'(v.len);
        ctl_setup = v.mode ? int'(v.ws) : int'(v.cs);
        oemask = '0;
        @(negedge clk);
        start_i = 1'b1; waddr_i = a; wdata_i = d; be_i = b;
        ctrl_sel_i = v.mode; we_setup_i = v.ws; we_pulse_i = v.wp;
        cs_setup_i = v.cs; cs_pulse_i = v.cp; cyc_len_i = v.len;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= l; k++) begin
            e_we   = low_at(k, int'(v.ws), int'(v.wp), l);
            e_cs   = low_at(k, int'(v.cs), int'(v.cp), l);
            e_oe   = (k < l) && (k >= ctl_setup);
            e_done = (k == l - 1);
            oemask[k] = dq_oe_o;
            if (k < l)
                check(req, {34'd0, cs_n_o, we_n_o, dq_oe_o, done_o, bsel_n_o,
                            waddr_o, dq_o},
                           {34'd0, !e_cs, !e_we, e_oe, e_done, ~b, a,
                            e_oe ? d : 32'd0});
            else
                check_idle({req, " R9 idle after done"});
            if (disturb && k == 2) begin
                start_i = 1'b1; waddr_i = ~a; wdata_i = ~d; be_i = ~b;
                ctrl_sel_i = ~v.mode; we_setup_i = 6'd0; we_pulse_i = 6'd1;
                cs_setup_i = 6'd0; cs_pulse_i = 6'd1; cyc_len_i = 6'd2;
            end
            if (k == l) start_i = 1'b0;
            if (k < l) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] m;
        // R1: reset state.
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset");

        // Table walk: R2 R3 R4 R5 R6 R7 R9.
        for (int i = 0; i < NVEC; i++) begin
            run_access(VECS[i], 24'hA50000 + 24'(i), 32'hC0DE0000 + 32'(i * 17),
                       4'(i + 5), $sformatf("R3/R7 vec%0d", i), 1'b0, m);
            oe_mask[i] = m;
        end

        // R4 / R5: driver timing unchanged when only the other strobe changes.
        check("R4 oe independent of cs timing", {32'd0, oe_mask[1]},
              {32'd0, oe_mask[0]});
        check("R5 oe independent of we timing", {32'd0, oe_mask[3]},
              {32'd0, oe_mask[2]});

        // R8 / R10: start and input changes during an access are ignored.
        run_access('{1'b1, 6'd1, 6'd3, 6'd0, 6'd5, 6'd6}, 24'h123456,
                   32'h89ABCDEF, 4'b0110, "R8/R10 disturbed strobe mode",
                   1'b1, m);
        run_access('{1'b0, 6'd4, 6'd1, 6'd2, 6'd2, 6'd5}, 24'h00FF00,
                   32'h5A5AA5A5, 4'b1001, "R8/R10 disturbed select mode",
                   1'b1, m);

        // R1: reset in the middle of an access.
        @(negedge clk);
        start_i = 1'b1; ctrl_sel_i = 1'b1; we_setup_i = 6'd0;
        we_pulse_i = 6'd6; cs_setup_i = 6'd0; cs_pulse_i = 6'd6;
        cyc_len_i = 6'd8; be_i = 4'hF; wdata_i = 32'hFFFF0000;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check("R1 access running before reset",
              {93'd0, cs_n_o, we_n_o, dq_oe_o}, {93'd0, 1'b0, 1'b0, 1'b1});
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_idle("R1 mid-access reset");
        @(negedge clk);
        check_idle("R1 stays idle after reset");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule